// File: doc/BRIEF.md
# Return-to-Zero Bit Codec

This block sends and receives single bits on a shared open-drain wire. Each bit occupies a cell of interface clocks, and every cell begins with the wire pulled low. A one is a short low followed by a long high, and a zero is a long low followed by a short high. Two cell lengths are supported. The block starts in the slower, longer-cell format and moves to the faster one only when asked to, and only once the wire is quiet. The line input is resynchronised, and the length of each low run is measured to decide the received bit.

A low that lasts far longer than any legal cell means the far end wants to restart the conversation. The codec then raises a one-cycle reset pulse and falls back to slow speed. When the far end releases the wire, the codec pulls the line low for a fixed synchronisation period so the far end can measure the interface clock. While the codec drives a cell it does not report its own bits as received. It does keep watching the wire, and it flags any low it did not cause during its high phase as a lost arbitration.

The transmit side is a valid/ready stream with no side buffer. A bit transfers on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_valid` may be held for any length of time, and `tx_bit` must stay stable while it waits. `tx_ready` stays low while a cell or a synchronisation frame is in progress, while one is owed, or while the synchronised line reads low. The receive side has no back-pressure: `rx_valid` is a one-cycle strobe that the consumer must take in the cycle it appears.

Top module: `rz_bit_codec`

## Requirements
- R1: In fast format a transmitted cell lasts 10 clocks of `tx_ready` low. A one drives the line low for the first 2 clocks and a zero for the first 8.
- R2: In slow format a transmitted cell lasts 22 clocks. A one drives low for the first 2 clocks and a zero for the first 20.
- R3: In fast format a received low run of 1 to 4 samples yields `rx_bit`=1, and a run of 5 or more (up to 64) yields `rx_bit`=0. Either result comes as one `rx_valid` strobe after the line returns high.
- R4: In slow format a received low run of up to 8 samples yields `rx_bit`=1, and a run of 9 to 64 samples yields `rx_bit`=0.
- R5: After reset the block is in slow format (`hs_active`=0), the line is released, and neither `rx_valid` nor `comm_reset` is high. `tx_ready` rises within 3 clocks.
- R6: A speed request (`spd_req` pulse with the target format in `spd_req_hs`, 1 meaning fast) is held pending. It takes effect only in a cycle where no cell is being sent and the line is high and quiet. A request made during a cell changes `hs_active` only after that cell ends.
- R7: A foreign low run of more than 64 samples produces exactly one `comm_reset` pulse, forces `hs_active` to 0, drops any pending speed request, and yields no `rx_valid`. A run of exactly 64 decodes as a zero with no reset.
- R8: After a communication reset, once the line is released, the codec drives the line low for exactly 128 clocks. `tx_ready` stays low from the reset pulse until that frame ends.
- R9: Low runs that begin while the codec is transmitting (its own cells or synchronisation frame) never produce `rx_valid`.
- R10: If the line is seen low while the codec's own cell is in its released phase, `arb_lost` is raised. A cell sent with no interference raises no `arb_lost`.
- R11: The line is never driven low while `tx_ready` is high. A bit is accepted only on a cycle with both `tx_valid` and `tx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw wire level (1 = released) |
| line_drive_low | output | 1 | Pull the open-drain wire low |
| tx_valid | input | 1 | Transmit bit offered |
| tx_ready | output | 1 | Codec can accept a transmit bit |
| tx_bit | input | 1 | Bit value to send |
| rx_valid | output | 1 | One-cycle strobe: a foreign bit was decoded |
| rx_bit | output | 1 | Decoded bit value |
| spd_req | input | 1 | Pulse: request a format change |
| spd_req_hs | input | 1 | Requested format, 1 = fast |
| hs_active | output | 1 | Current format, 1 = fast |
| comm_reset | output | 1 | One-cycle pulse on a detected long low |
| arb_lost | output | 1 | Foreign low seen during own released phase |

## Verification
The hardest situations to reach from the ports are the communication reset and its aftermath. The long foreign low must outlast the detector but then hand the wire back, so that the codec's own 128-clock frame can be timed while the receive path must stay silent. The bench models the wire as a wired-AND of the codec's drive and a host pull-down. It holds the host low for 70 clocks, releases it, and measures the returning low run. Arbitration loss is reached the same way: the host pulls the wire low a few clocks into a fast-format one cell, which lands inside the codec's released phase.

// File: rtl/rz_codec_pkg.sv
package rz_codec_pkg;
  typedef enum logic {
    SPD_SLOW = 1'b0,
    SPD_FAST = 1'b1
  } rz_speed_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_CELL = 2'd1,
    TX_SYNC = 2'd2
  } rz_tx_state_e;
endpackage

// File: rtl/rz_line_rx.sv
module rz_line_rx #(
  parameter int FAST_THR = 4,
  parameter int SLOW_THR = 8,
  parameter int LONG_LOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic fast,
  input  logic own_drive,
  input  logic own_busy,
  output logic line_hi,
  output logic in_run,
  output logic quiet,
  output logic rx_valid,
  output logic rx_bit,
  output logic long_low,
  output logic arb_lost
);
  localparam int CW = $clog2(LONG_LOW + 2);
  localparam logic [CW-1:0] LONG_C = CW'(LONG_LOW);
  localparam logic [CW-1:0] SAT_C  = CW'(LONG_LOW + 1);

  logic [1:0]    sync_q;
  logic [1:0]    drv_dly;
  logic [1:0]    obs_dly;
  logic [CW-1:0] run_cnt;
  logic          run_own;
  logic          run_long;
  logic [CW-1:0] thr;

  assign line_hi = sync_q[1];
  assign quiet   = ~|obs_dly;
  assign thr     = fast ? CW'(FAST_THR) : CW'(SLOW_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      drv_dly  <= '0;
      obs_dly  <= '0;
      in_run   <= 1'b0;
      run_cnt  <= '0;
      run_own  <= 1'b0;
      run_long <= 1'b0;
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
      long_low <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], line_in};
      drv_dly  <= {drv_dly[0], own_drive};
      obs_dly  <= {obs_dly[0], own_busy};
      rx_valid <= 1'b0;
      long_low <= 1'b0;
      arb_lost <= obs_dly[1] && !drv_dly[1] && !line_hi;
      if (!in_run) begin
        if (!line_hi) begin
          in_run   <= 1'b1;
          run_cnt  <= CW'(1);
          run_own  <= drv_dly[1] | obs_dly[1];
          run_long <= 1'b0;
        end
      end else if (!line_hi) begin
        if (run_cnt != SAT_C) run_cnt <= run_cnt + CW'(1);
        if (run_cnt == LONG_C && !run_own) begin
          long_low <= 1'b1;
          run_long <= 1'b1;
        end
      end else begin
        in_run   <= 1'b0;
        rx_valid <= !run_own && !run_long;
        rx_bit   <= (run_cnt <= thr);
      end
    end
  end
endmodule

// File: rtl/rz_line_tx.sv
module rz_line_tx
  import rz_codec_pkg::*;
#(
  parameter int FAST_CELL   = 10,
  parameter int SLOW_CELL   = 22,
  parameter int SHORT_LOW   = 2,
  parameter int FAST_ZERO   = 8,
  parameter int SLOW_ZERO   = 20,
  parameter int SYNC_LEN    = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic line_hi,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready,
  input  logic sync_req,
  output logic drive_low,
  output logic active
);
  localparam int MAXC = (SYNC_LEN > SLOW_CELL) ? SYNC_LEN : SLOW_CELL;
  localparam int CW   = $clog2(MAXC + 1);

  rz_tx_state_e  state;
  logic [CW-1:0] cnt;
  logic          bit_q;
  logic          sync_pend;
  logic [CW-1:0] low_len;
  logic [CW-1:0] cell_last;

  assign low_len   = bit_q ? CW'(SHORT_LOW) : (fast ? CW'(FAST_ZERO) : CW'(SLOW_ZERO));
  assign cell_last = fast ? CW'(FAST_CELL - 1) : CW'(SLOW_CELL - 1);
  assign tx_ready  = (state == TX_IDLE) && !sync_pend && line_hi;
  assign drive_low = ((state == TX_CELL) && (cnt < low_len)) || (state == TX_SYNC);
  assign active    = (state != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      cnt       <= '0;
      bit_q     <= 1'b0;
      sync_pend <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (sync_pend && line_hi) begin
            state     <= TX_SYNC;
            cnt       <= '0;
            sync_pend <= 1'b0;
          end else if (tx_valid && tx_ready) begin
            state <= TX_CELL;
            cnt   <= '0;
            bit_q <= tx_bit;
          end
        end
        TX_CELL: begin
          if (cnt == cell_last) state <= TX_IDLE;
          else cnt <= cnt + CW'(1);
        end
        TX_SYNC: begin
          if (cnt == CW'(SYNC_LEN - 1)) state <= TX_IDLE;
          else cnt <= cnt + CW'(1);
        end
        default: state <= TX_IDLE;
      endcase
      if (sync_req) sync_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/rz_bit_codec.sv
module rz_bit_codec
  import rz_codec_pkg::*;
#(
  parameter int FAST_CELL = 10,
  parameter int SLOW_CELL = 22,
  parameter int SHORT_LOW = 2,
  parameter int FAST_ZERO = 8,
  parameter int SLOW_ZERO = 20,
  parameter int FAST_THR  = 4,
  parameter int SLOW_THR  = 8,
  parameter int LONG_LOW  = 64,
  parameter int SYNC_LEN  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_drive_low,
  input  logic tx_valid,
  output logic tx_ready,
  input  logic tx_bit,
  output logic rx_valid,
  output logic rx_bit,
  input  logic spd_req,
  input  logic spd_req_hs,
  output logic hs_active,
  output logic comm_reset,
  output logic arb_lost
);
  rz_speed_e speed_q;
  logic      pend_v;
  logic      pend_fast;
  logic      fast;
  logic      line_hi;
  logic      in_run;
  logic      quiet;
  logic      tx_active;
  logic      idle;

  assign fast      = (speed_q == SPD_FAST);
  assign hs_active = fast;
  assign idle      = !tx_active && quiet && line_hi && !in_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q   <= SPD_SLOW;
      pend_v    <= 1'b0;
      pend_fast <= 1'b0;
    end else if (comm_reset) begin
      speed_q <= SPD_SLOW;
      pend_v  <= 1'b0;
    end else if (spd_req) begin
      pend_v    <= 1'b1;
      pend_fast <= spd_req_hs;
    end else if (pend_v && idle) begin
      speed_q <= pend_fast ? SPD_FAST : SPD_SLOW;
      pend_v  <= 1'b0;
    end
  end

  rz_line_rx #(
    .FAST_THR(FAST_THR), .SLOW_THR(SLOW_THR), .LONG_LOW(LONG_LOW)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .fast(fast),
    .own_drive(line_drive_low), .own_busy(tx_active),
    .line_hi(line_hi), .in_run(in_run), .quiet(quiet),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .long_low(comm_reset),
    .arb_lost(arb_lost)
  );

  rz_line_tx #(
    .FAST_CELL(FAST_CELL), .SLOW_CELL(SLOW_CELL), .SHORT_LOW(SHORT_LOW),
    .FAST_ZERO(FAST_ZERO), .SLOW_ZERO(SLOW_ZERO), .SYNC_LEN(SYNC_LEN)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .fast(fast), .line_hi(line_hi),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
    .sync_req(comm_reset), .drive_low(line_drive_low), .active(tx_active)
  );
endmodule

// File: rtl/rz_bit_codec_chk.sv
module rz_bit_codec_chk #(
  parameter int SHORT_LOW = 2,
  parameter int FAST_ZERO = 8,
  parameter int SLOW_ZERO = 20,
  parameter int SYNC_LEN  = 128
) (
  input logic clk,
  input logic rst_n,
  input logic line_drive_low,
  input logic tx_ready,
  input logic rx_valid,
  input logic hs_active,
  input logic comm_reset
);
  localparam int RW = $clog2(SYNC_LEN + 2);
  logic [RW-1:0] drive_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_run <= '0;
    else if (line_drive_low) drive_run <= drive_run + RW'(1);
    else drive_run <= '0;
  end

  AST_DRIVE_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_drive_low) |-> (drive_run == RW'(SHORT_LOW) || drive_run == RW'(FAST_ZERO) ||
                               drive_run == RW'(SLOW_ZERO) || drive_run == RW'(SYNC_LEN))); // R1
  AST_DRIVE_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> (drive_run < RW'(SYNC_LEN))); // R8
  AST_SPEED_UP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active) |-> $past(!line_drive_low)); // R6
  AST_RESET_SLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    comm_reset |=> !hs_active); // R7
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, comm_reset})); // R7
  AST_NO_READY_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> !tx_ready); // R11
endmodule

bind rz_bit_codec rz_bit_codec_chk #(
  .SHORT_LOW(SHORT_LOW), .FAST_ZERO(FAST_ZERO), .SLOW_ZERO(SLOW_ZERO), .SYNC_LEN(SYNC_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_drive_low(line_drive_low), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .hs_active(hs_active), .comm_reset(comm_reset)
);

// File: tb/rz_bit_codec_bench.sv
module rz_bit_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic line_in;
  logic line_drive_low, tx_valid = 1'b0, tx_ready, tx_bit = 1'b0;
  logic rx_valid, rx_bit, spd_req = 1'b0, spd_req_hs = 1'b0;
  logic hs_active, comm_reset, arb_lost;

  int checks = 0, fails = 0;
  int rx_cnt = 0, cr_cnt = 0, arb_cnt = 0;
  logic last_bit = 1'b0;

  always #2 clk = ~clk;
  assign line_in = ~(host_low | line_drive_low);

  rz_bit_codec u_rz_bit_codec (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_drive_low(line_drive_low),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bit(tx_bit),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .spd_req(spd_req), .spd_req_hs(spd_req_hs),
    .hs_active(hs_active), .comm_reset(comm_reset), .arb_lost(arb_lost)
  );

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin rx_cnt++; last_bit = rx_bit; end
    if (comm_reset) cr_cnt++;
    if (arb_lost) arb_cnt++;
  end

  localparam int NV = 9;
  localparam int V_HS  [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0};
  localparam int V_LEN [NV] = '{1, 4, 5, 8, 2, 8, 9, 20, 64};
  localparam int V_BIT [NV] = '{1, 1, 0, 0, 1, 1, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_speed(input bit v);
    @(negedge clk); spd_req = 1'b1; spd_req_hs = v;
    @(negedge clk); spd_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_pulse(input int n);
    @(negedge clk); host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic offer(input bit b);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_bit = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic send_measure(input bit b, output int low, output int tot);
    offer(b);
    low = 0; tot = 0;
    while (!tx_ready && tot < 400) begin
      if (line_drive_low) low++;
      tot++;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int low, tot, r0, c0, a0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(hs_active == 1'b0, "R5 speed", hs_active, 0);
    chk(line_drive_low == 1'b0, "R5 drive", line_drive_low, 0);
    chk(!rx_valid && !comm_reset, "R5 strobes", rx_valid, 0);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R5 ready", tx_ready, 1);

    // R3 / R4 receive thresholds from the vector table
    for (int i = 0; i < NV; i++) begin
      set_speed(V_HS[i] != 0);
      chk(hs_active == (V_HS[i] != 0), "R6 speed applied", hs_active, V_HS[i]);
      r0 = rx_cnt; c0 = cr_cnt;
      host_pulse(V_LEN[i]);
      chk(rx_cnt == r0 + 1, V_HS[i] != 0 ? "R3 strobe" : "R4 strobe", rx_cnt - r0, 1);
      chk(last_bit == V_BIT[i], V_HS[i] != 0 ? "R3 bit" : "R4 bit", last_bit, V_BIT[i]);
      chk(cr_cnt == c0, "R7 no reset at or below limit", cr_cnt - c0, 0);
    end

    // R1 fast cells, R2 slow cells, R9 no self reception, R10 no false arb
    r0 = rx_cnt; a0 = arb_cnt;
    set_speed(1'b1);
    send_measure(1'b1, low, tot);
    chk(low == 2 && tot == 10, "R1 fast one", low * 100 + tot, 210);
    send_measure(1'b0, low, tot);
    chk(low == 8 && tot == 10, "R1 fast zero", low * 100 + tot, 810);
    set_speed(1'b0);
    send_measure(1'b1, low, tot);
    chk(low == 2 && tot == 22, "R2 slow one", low * 100 + tot, 222);
    send_measure(1'b0, low, tot);
    chk(low == 20 && tot == 22, "R2 slow zero", low * 100 + tot, 2022);
    chk(rx_cnt == r0, "R9 own cells silent", rx_cnt - r0, 0);
    chk(arb_cnt == a0, "R10 clean cells", arb_cnt - a0, 0);

    // R6 request during a slow cell is deferred
    offer(1'b0);
    spd_req = 1'b1; spd_req_hs = 1'b1;
    @(negedge clk); spd_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(hs_active == 1'b0, "R6 deferred", hs_active, 0);
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(hs_active == 1'b1, "R6 applied after cell", hs_active, 1);

    // R10 arbitration loss inside fast one cell, R9 its run suppressed
    r0 = rx_cnt; a0 = arb_cnt;
    offer(1'b1);
    repeat (3) @(negedge clk);
    host_low = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    while (!tx_ready) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(arb_cnt > a0, "R10 arb lost", arb_cnt - a0, 1);
    chk(rx_cnt == r0, "R9 contested run silent", rx_cnt - r0, 0);

    // R7 long low, R8 sync frame
    r0 = rx_cnt; c0 = cr_cnt;
    @(negedge clk); host_low = 1'b1;
    repeat (70) @(negedge clk);
    chk(cr_cnt == c0 + 1, "R7 single reset pulse", cr_cnt - c0, 1);
    chk(hs_active == 1'b0, "R7 forced slow", hs_active, 0);
    chk(tx_ready == 1'b0, "R8 ready low", tx_ready, 0);
    host_low = 1'b0;
    n = 0;
    while (!line_drive_low && n < 20) begin @(negedge clk); n++; end
    low = 0;
    while (line_drive_low && low < 300) begin
      if (tx_ready) chk(1'b0, "R8 ready during frame", 1, 0);
      low++;
      @(negedge clk);
    end
    chk(low == 128, "R8 sync length", low, 128);
    repeat (8) @(negedge clk);
    chk(rx_cnt == r0, "R7 no decode of long or sync run", rx_cnt - r0, 0);
    chk(cr_cnt == c0 + 1, "R9 sync frame not a reset", cr_cnt - c0, 1);
    chk(tx_ready == 1'b1, "R11 ready after frame", tx_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule